// File: doc/BRIEF.md
# Frame Line Address Generator

This block produces the memory byte address at which each line of an image frame begins. Two configuration fields give the frame's start location. An 11-bit upper part and a 16-bit lower part are joined into a 27-bit count of 32-byte units. A 12-bit line pitch, also counted in 32-byte units, sets the distance between consecutive lines. A direction bit makes lines run toward lower addresses, so the frame lands in memory vertically flipped.

A start-of-frame pulse captures the whole configuration and places the first line address on the output. Each later start-of-line pulse moves the address by one pitch. Every new address is marked by a one-cycle valid strobe. Configuration inputs may change at any time; they are sampled only at the start of a frame.

Top module: `frame_line_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `line_addr_o` is 0 and `line_valid_o` is 0.
- R2: A cycle with `sof_i` high causes, in the next cycle, `line_addr_o` = ({`cfg_base_hi`,`cfg_base_lo`} with the high field in the upper bits) × 32, using the field values present in the `sof_i` cycle, together with `line_valid_o` = 1.
- R3: With the captured direction bit 0, a cycle with `sol_i` high (and `sof_i` low) after a frame start makes the next-cycle `line_addr_o` equal to the previous address plus pitch × 32, with `line_valid_o` = 1.
- R4: With the captured direction bit 1, the same step subtracts pitch × 32 instead.
- R5: Address arithmetic wraps modulo 2^32 in both directions.
- R6: Changes to `cfg_base_hi`, `cfg_base_lo`, `cfg_pitch` and `cfg_flip` have no effect until the next `sof_i`.
- R7: `line_valid_o` is high for exactly one cycle per produced address; in a cycle after one with neither event, `line_valid_o` is 0 and `line_addr_o` is unchanged.
- R8: When `sof_i` and `sol_i` are high in the same cycle, only the frame load takes place.
- R9: `sol_i` pulses after reset and before the first `sof_i` are ignored: no strobe, address stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_hi | input | 11 | Upper part of frame start, 32-byte units |
| cfg_base_lo | input | 16 | Lower part of frame start, 32-byte units |
| cfg_pitch | input | 12 | Line-to-line distance, 32-byte units |
| cfg_flip | input | 1 | 1 = lines descend in memory |
| sof_i | input | 1 | Start-of-frame pulse |
| sol_i | input | 1 | Start-of-line pulse |
| line_addr_o | output | 32 | Current line byte address |
| line_valid_o | output | 1 | One-cycle strobe on each new address |

## Verification
The hardest condition to reach is a wrap across 2^32. Reaching it from the ports takes a start near the top or bottom of the address space and enough steps of a large pitch to cross the boundary. The stimulus loads the highest upper and lower fields with the largest pitch and steps upward. It then loads a zero base with the direction bit set and steps downward. Around these runs it changes the configuration in the middle of frames and raises both events together. A behavioural model checks every cycle.

// File: rtl/fla_pkg.sv
package fla_pkg;
  parameter int HI_W   = 11;
  parameter int LO_W   = 16;
  parameter int PITCH_W = 12;
  parameter int GRAN_SH = 5;
  localparam int ADDR_W = HI_W + LO_W + GRAN_SH;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic [HI_W-1:0]    base_hi;
    logic [LO_W-1:0]    base_lo;
    logic [PITCH_W-1:0] pitch;
    logic               flip;
  } fla_cfg_t;

  function automatic addr_t base_bytes(input logic [HI_W-1:0] hi,
                                       input logic [LO_W-1:0] lo);
    return {hi, lo, {GRAN_SH{1'b0}}};
  endfunction

  function automatic addr_t pitch_bytes(input logic [PITCH_W-1:0] p);
    addr_t r;
    r = '0;
    r[PITCH_W+GRAN_SH-1:GRAN_SH] = p;
    return r;
  endfunction

  function automatic addr_t next_line(input addr_t cur,
                                      input logic [PITCH_W-1:0] p,
                                      input logic down);
    return down ? cur - pitch_bytes(p) : cur + pitch_bytes(p);
  endfunction
endpackage

// File: rtl/fla_cfg_shadow.sv
module fla_cfg_shadow
  import fla_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  fla_cfg_t cfg_in,
  output fla_cfg_t cfg_held,
  output logic     frame_open
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_held   <= '0;
      frame_open <= 1'b0;
    end else if (capture) begin
      cfg_held   <= cfg_in;
      frame_open <= 1'b1;
    end
  end

  // R6: held configuration only moves on a frame start
  a_r6_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cfg_held));
endmodule

// File: rtl/fla_line_stepper.sv
module fla_line_stepper
  import fla_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               step_en,
  input  addr_t              load_addr,
  input  logic [PITCH_W-1:0] pitch,
  input  logic               down,
  output addr_t              addr,
  output logic               valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load_en | step_en;
      if (load_en)      addr <= load_addr;
      else if (step_en) addr <= next_line(addr, pitch, down);
    end
  end

  // R3 / R4 / R5: distance between consecutive addresses is one pitch
  a_r3_step_distance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !down) |=> (addr - $past(addr) == pitch_bytes($past(pitch))));
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && down) |=> ($past(addr) - addr == pitch_bytes($past(pitch))));
  // R7: address holds when nothing happens
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> ($stable(addr) && !valid));
endmodule

// File: rtl/frame_line_addr_gen.sv
module frame_line_addr_gen
  import fla_pkg::*;
#(
  parameter int BASE_HI_W = fla_pkg::HI_W,
  parameter int BASE_LO_W = fla_pkg::LO_W,
  parameter int STEP_W    = fla_pkg::PITCH_W,
  localparam int OUT_W    = fla_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BASE_HI_W-1:0] cfg_base_hi,
  input  logic [BASE_LO_W-1:0] cfg_base_lo,
  input  logic [STEP_W-1:0]    cfg_pitch,
  input  logic                 cfg_flip,
  input  logic                 sof_i,
  input  logic                 sol_i,
  output logic [OUT_W-1:0]     line_addr_o,
  output logic                 line_valid_o
);
  fla_cfg_t cfg_now, cfg_held;
  logic     frame_open;
  logic     ev_load, ev_step;
  addr_t    addr_q;

  assign cfg_now = '{base_hi: cfg_base_hi, base_lo: cfg_base_lo,
                     pitch: cfg_pitch, flip: cfg_flip};

  // Named events: frame load has priority over a line step (R8)
  assign ev_load = sof_i;
  assign ev_step = sol_i & frame_open & ~sof_i;

  fla_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .capture(ev_load),
    .cfg_in(cfg_now), .cfg_held(cfg_held), .frame_open(frame_open)
  );

  fla_line_stepper u_step (
    .clk(clk), .rst_n(rst_n), .load_en(ev_load), .step_en(ev_step),
    .load_addr(base_bytes(cfg_base_hi, cfg_base_lo)),
    .pitch(cfg_held.pitch), .down(cfg_held.flip),
    .addr(addr_q), .valid(line_valid_o)
  );

  assign line_addr_o = addr_q;

  // R2: frame start places the captured base on the output
  a_r2_sof_load: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (line_valid_o && line_addr_o[GRAN_SH-1:0] == '0 &&
               line_addr_o[OUT_W-1:GRAN_SH] == {$past(cfg_base_hi), $past(cfg_base_lo)}));
  // R7: strobe only follows an event
  a_r7_valid_cause: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid_o |-> $past(sof_i || (sol_i && frame_open)));
  // R9: line pulse before any frame does nothing
  a_r9_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_open && !sof_i) |=> !line_valid_o);
endmodule

// File: tb/frame_line_addr_gen_tb_top.sv
module frame_line_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_base_hi = '0;
  logic [15:0] cfg_base_lo = '0;
  logic [11:0] cfg_pitch = '0;
  logic        cfg_flip = 1'b0;
  logic        sof_i = 1'b0, sol_i = 1'b0;
  logic [31:0] line_addr_o;
  logic        line_valid_o;

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  frame_line_addr_gen dut_i (.*);

  // behavioural reference: integers, not the design's structure
  longint m_addr = 0, s_base = 0, s_pitch = 0;
  bit m_valid = 0, m_open = 0, s_down = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_valid = 0; m_open = 0; s_base = 0; s_pitch = 0; s_down = 0;
    end else if (sof_i) begin
      s_base  = (longint'(cfg_base_hi) * 65536 + longint'(cfg_base_lo)) * 32;
      s_pitch = longint'(cfg_pitch) * 32;
      s_down  = cfg_flip;
      m_open  = 1; m_addr = s_base; m_valid = 1;
    end else if (sol_i && m_open) begin
      m_addr  = s_down ? m_addr - s_pitch : m_addr + s_pitch;
      m_addr  = m_addr % 64'sh1_0000_0000;
      if (m_addr < 0) m_addr += 64'sh1_0000_0000;
      m_valid = 1;
    end else m_valid = 0;
  end

  always @(negedge clk) if (!done) begin
    cycles++;
    vectors++;
    if (line_addr_o !== m_addr[31:0] || line_valid_o !== m_valid) begin
      miscompares++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               cur_req, line_addr_o, line_valid_o, m_addr[31:0], m_valid);
    end
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(bit f, bit l);
    @(negedge clk); sof_i = f; sol_i = l;
    @(negedge clk); sof_i = 0; sol_i = 0;
  endtask

  task automatic set_cfg(logic [10:0] h, logic [15:0] l, logic [11:0] p, bit d);
    cfg_base_hi = h; cfg_base_lo = l; cfg_pitch = p; cfg_flip = d;
  endtask

  initial begin
    cur_req = "R1"; tick(3);
    @(negedge clk); rst_n = 1; tick(2);
    cur_req = "R9"; set_cfg(11'h12, 16'h3456, 12'h40, 0);
    pulse(0, 1); pulse(0, 1); tick(1);
    cur_req = "R2"; pulse(1, 0);
    cur_req = "R3"; pulse(0, 1); pulse(0, 1);
    cur_req = "R7"; @(negedge clk); sol_i = 1; tick(3); sol_i = 0; tick(2);
    cur_req = "R6"; set_cfg(11'h7ff, 16'h0001, 12'h001, 1);
    pulse(0, 1); pulse(0, 1); tick(1);
    cur_req = "R4"; set_cfg(11'h100, 16'h8000, 12'h123, 1);
    pulse(1, 0); pulse(0, 1); pulse(0, 1); pulse(0, 1);
    cur_req = "R5"; set_cfg(11'h7ff, 16'hffff, 12'hfff, 0);
    pulse(1, 0); for (int i = 0; i < 3; i++) pulse(0, 1);
    set_cfg(11'h000, 16'h0000, 12'hfff, 1);
    pulse(1, 0); for (int i = 0; i < 3; i++) pulse(0, 1);
    cur_req = "R8"; set_cfg(11'h055, 16'haaaa, 12'h010, 0);
    pulse(1, 1); pulse(0, 1); pulse(1, 1);
    cur_req = "R1"; @(negedge clk); rst_n = 0; tick(2); rst_n = 1;
    cur_req = "R9"; pulse(0, 1); tick(2);
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin
      set_cfg(11'(i * 97), 16'(i * 4099), 12'(i * 211), i[0]);
      pulse(1, 0);
      for (int j = 0; j < 4; j++) pulse(0, 1);
    end
    tick(3);
    finish_run();
  end
endmodule